// File: doc/BRIEF.md
# Host Byte-Lane Receive Register

This block is the receive side of a parallel host port. A host with an 8-bit data bus and a 3-bit address writes a word one byte at a time into a four-slot window. Three slots hold the high, middle and low bytes of a 24-bit word. The fourth slot sits at the bottom of the window and exists only as padding. A host that is 16 or 32 bits wide can therefore issue its natural accesses across the whole window. The byte that lands in the padding slot is thrown away.

The bytes collect in holding latches. A write to the low-byte slot is the only event that moves a word to the processor side. In the cycle after that write, the 24-bit receive register shows the high and middle latches joined with the new low byte, and a word-ready strobe is high for that one cycle. The host must write the low byte last. Any byte written after it belongs to the next word. The latches keep their values across a transfer, so a host that only changes the low byte can reuse the upper two.

Top module: `hbl_rx_port`

## Requirements
- R1: Synchronous active-high reset clears the three holding latches and the receive register to zero and holds the word-ready strobe low.
- R2: A write to address 5 stores the data byte in the high latch. It changes neither the receive register nor the strobe.
- R3: A write to address 6 stores the data byte in the middle latch. It changes neither the receive register nor the strobe.
- R4: A write to address 7 in cycle N has two results in cycle N+1. The receive register holds {high latch, middle latch, written byte}, with the high latch in bits 23:16 and the written byte in bits 7:0. The strobe is high for exactly that one cycle.
- R5: Address 4 is the padding slot. A write there changes no latch, register or strobe, and a read there returns 0x00. A 32-bit host write to addresses 4 to 7 therefore yields only its lowest 24 bits.
- R6: Addresses 0 to 3 are outside the window. Writes there have no effect, and reads there return 0x00.
- R7: The latches keep their values after a transfer. Bytes written after a low-byte write form the next word. Low-byte writes in consecutive cycles give a strobe and a new word in each following cycle.
- R8: Reading addresses 5, 6 and 7 returns the current content of the high, middle and low latch respectively. The read is combinational from the address.
- R9: While the write enable is low, neither the latches nor the receive register change, and the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Host byte address |
| host_we | input | 1 | Host write enable for the current cycle |
| host_wdata | input | 8 | Host write data byte |
| host_rdata | output | 8 | Host read data for host_addr |
| rx_word | output | 24 | Receive register toward the processor side |
| rx_valid | output | 1 | Word-ready strobe, one cycle per low-byte write |

## Verification
The bench builds the block with its default parameters: three 8-bit lanes, the window based at address 4, and a 3-bit address. With these values every host address from 0 to 7 can be reached, so the outside slots, the padding slot and all three lanes are each driven and read. The default window ends exactly at the top of the address space, which puts the transfer trigger on the highest address. Back-to-back low-byte writes and a full four-byte host write with a non-zero padding byte are included.

// File: rtl/hbl_pkg.sv
package hbl_pkg;

    localparam int unsigned DEF_BYTE_W    = 8;
    localparam int unsigned DEF_LANES     = 3;
    localparam int unsigned DEF_ADDR_W    = 3;
    localparam int unsigned DEF_BASE_ADDR = 4;
    localparam int unsigned LANE_IDX_W    = 4;

    typedef enum logic [1:0] {
        SLOT_NONE  = 2'd0,
        SLOT_DUMMY = 2'd1,
        SLOT_LANE  = 2'd2
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e             kind;
        logic [LANE_IDX_W-1:0]  lane;  // 0 = most significant lane
        logic                   last;  // lowest lane: triggers transfer
    } slot_t;

    function automatic slot_t decode_slot(input int unsigned addr,
                                          input int unsigned base,
                                          input int unsigned lanes);
        slot_t s;
        s.kind = SLOT_NONE;
        s.lane = '0;
        s.last = 1'b0;
        if (addr == base) begin
            s.kind = SLOT_DUMMY;
        end else if (addr > base && addr <= base + lanes) begin
            s.kind = SLOT_LANE;
            s.lane = LANE_IDX_W'(addr - base - 1);
            s.last = (addr == base + lanes);
        end
        return s;
    endfunction

endpackage

// File: rtl/hbl_decode.sv
module hbl_decode
    import hbl_pkg::*;
#(
    parameter int unsigned LANES     = DEF_LANES,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned BASE_ADDR = DEF_BASE_ADDR
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output slot_t             slot,
    output logic [LANES-1:0]  lane_we,
    output logic              load_word
);

    always_comb begin
        slot = decode_slot(int'(addr), BASE_ADDR, LANES);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane_we
        assign lane_we[i] = we && (slot.kind == SLOT_LANE)
                            && (slot.lane == LANE_IDX_W'(i));
    end

    assign load_word = we && (slot.kind == SLOT_LANE) && slot.last;

endmodule

// File: rtl/hbl_lane_hold.sv
module hbl_lane_hold
    import hbl_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    parameter int unsigned LANES  = DEF_LANES,
    localparam int unsigned WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [WORD_W-1:0] hold_flat
);

    // lane i sits at bit position (LANES-1-i)*BYTE_W: lane 0 is the top byte
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned LSB = (LANES - 1 - i) * BYTE_W;
        logic [BYTE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (lane_we[i]) begin
                q <= wdata;
            end
        end

        assign hold_flat[LSB +: BYTE_W] = q;
    end

endmodule

// File: rtl/hbl_assemble.sv
module hbl_assemble
    import hbl_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    parameter int unsigned LANES  = DEF_LANES,
    localparam int unsigned WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_word,
    input  logic [WORD_W-1:0] hold_flat,
    input  logic [BYTE_W-1:0] wdata,
    output logic [WORD_W-1:0] word_q,
    output logic              valid_q
);

    logic [WORD_W-1:0] word_next;

    // low byte comes straight from the bus; its latch loads on the same edge
    assign word_next = {hold_flat[WORD_W-1:BYTE_W], wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load_word;
            if (load_word) begin
                word_q <= word_next;
            end
        end
    end

endmodule

// File: rtl/hbl_readmux.sv
module hbl_readmux
    import hbl_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    parameter int unsigned LANES  = DEF_LANES,
    localparam int unsigned WORD_W = BYTE_W * LANES
) (
    input  slot_t             slot,
    input  logic [WORD_W-1:0] hold_flat,
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (slot.kind == SLOT_LANE) begin
            for (int i = 0; i < int'(LANES); i++) begin
                if (slot.lane == LANE_IDX_W'(i)) begin
                    rdata = hold_flat[(LANES - 1 - i) * BYTE_W +: BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/hbl_rx_port.sv
module hbl_rx_port
    import hbl_pkg::*;
#(
    parameter int unsigned BYTE_W    = DEF_BYTE_W,
    parameter int unsigned LANES     = DEF_LANES,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned BASE_ADDR = DEF_BASE_ADDR,
    localparam int unsigned WORD_W   = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    slot_t             slot;
    logic [LANES-1:0]  lane_we;
    logic              load_word;
    logic [WORD_W-1:0] hold_flat;

    hbl_decode #(
        .LANES     (LANES),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr      (host_addr),
        .we        (host_we),
        .slot      (slot),
        .lane_we   (lane_we),
        .load_word (load_word)
    );

    hbl_lane_hold #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .lane_we   (lane_we),
        .wdata     (host_wdata),
        .hold_flat (hold_flat)
    );

    hbl_assemble #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_asm (
        .clk       (clk),
        .rst       (rst),
        .load_word (load_word),
        .hold_flat (hold_flat),
        .wdata     (host_wdata),
        .word_q    (rx_word),
        .valid_q   (rx_valid)
    );

    hbl_readmux #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_rmux (
        .slot      (slot),
        .hold_flat (hold_flat),
        .rdata     (host_rdata)
    );

endmodule

// File: rtl/hbl_rx_port_chk.sv
module hbl_rx_port_chk
    import hbl_pkg::*;
#(
    parameter int unsigned BYTE_W    = DEF_BYTE_W,
    parameter int unsigned LANES     = DEF_LANES,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned BASE_ADDR = DEF_BASE_ADDR,
    localparam int unsigned WORD_W   = BYTE_W * LANES
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_we,
    input logic [BYTE_W-1:0] host_wdata,
    input logic [BYTE_W-1:0] host_rdata,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_valid,
    input logic [WORD_W-1:0] hold_flat
);

    localparam logic [ADDR_W-1:0] DUMMY_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] HIGH_A  = ADDR_W'(BASE_ADDR + 1);
    localparam logic [ADDR_W-1:0] LOW_A   = ADDR_W'(BASE_ADDR + LANES);

    logic low_wr;
    assign low_wr = host_we && (host_addr == LOW_A);

    assert_word_load_R4: assert property (@(posedge clk) disable iff (rst)
        low_wr |=> (rx_valid &&
                    rx_word == {$past(hold_flat[WORD_W-1:BYTE_W]), $past(host_wdata)}));

    assert_strobe_cause_R4: assert property (@(posedge clk) disable iff (rst)
        !low_wr |=> !rx_valid);

    assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !low_wr |=> $stable(rx_word));

    assert_high_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == HIGH_A) |=>
            hold_flat[WORD_W-1 -: BYTE_W] == $past(host_wdata));

    assert_dummy_read_R5: assert property (@(posedge clk) disable iff (rst)
        (host_addr == DUMMY_A) |-> host_rdata == '0);

    assert_outside_read_R6: assert property (@(posedge clk) disable iff (rst)
        (host_addr < DUMMY_A) |-> host_rdata == '0);

endmodule

bind hbl_rx_port hbl_rx_port_chk #(
    .BYTE_W    (BYTE_W),
    .LANES     (LANES),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rx_word    (rx_word),
    .rx_valid   (rx_valid),
    .hold_flat  (hold_flat)
);

// File: tb/hbl_rx_port_test.sv
module hbl_rx_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_we = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [23:0] rx_word;
    logic        rx_valid;

    int n_checks = 0;
    int n_fails  = 0;

    // behavioural reference state
    int m_lane [3];
    int m_word;
    bit m_valid;

    always #10 clk = ~clk;  // 50 MHz

    hbl_rx_port uut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid)
    );

    function automatic int model_read(input int a);
        if (a >= 5 && a <= 7) return m_lane[a - 5];
        return 0;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // one host cycle: drive at negedge, check read data, clock, check outputs
    task automatic step(input string tag, input bit we, input int a, input int d);
        host_we    = we;
        host_addr  = 3'(a);
        host_wdata = 8'(d);
        #1;
        check(tag, "rdata", int'(host_rdata), model_read(a));
        @(posedge clk);
        m_valid = 1'b0;
        if (we) begin
            if (a >= 5 && a <= 7) m_lane[a - 5] = d & 8'hFF;
            if (a == 7) begin
                m_word  = (m_lane[0] << 16) | (m_lane[1] << 8) | m_lane[2];
                m_valid = 1'b1;
            end
        end
        @(negedge clk);
        check(tag, "rx_word", int'(rx_word), m_word);
        check(tag, "rx_valid", int'(rx_valid), int'(m_valid));
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        foreach (m_lane[i]) m_lane[i] = 0;
        m_word  = 0;
        m_valid = 0;
        repeat (3) @(negedge clk);
        host_we = 1'b1;  // a write during reset must not stick
        host_addr = 3'd7;
        host_wdata = 8'h5A;
        @(negedge clk);
        rst = 1'b0;
        host_we = 1'b0;
        // R1: reset state
        check("R1", "rx_word", int'(rx_word), 0);
        check("R1", "rx_valid", int'(rx_valid), 0);
        for (int a = 5; a <= 7; a++) step("R1", 1'b0, a, 0);

        // R2, R3, R8: upper lanes latch and read back without a transfer
        step("R2", 1'b1, 5, 'hAB);
        step("R8", 1'b0, 5, 0);
        step("R3", 1'b1, 6, 'hCD);
        step("R8", 1'b0, 6, 0);
        // R4: low-byte write transfers, strobe for one cycle
        step("R4", 1'b1, 7, 'hEF);
        step("R4", 1'b0, 7, 0);
        step("R8", 1'b0, 7, 0);

        // R5: padding slot
        step("R5", 1'b1, 4, 'h77);
        step("R5", 1'b0, 4, 0);
        // R6: outside addresses
        for (int a = 0; a < 4; a++) step("R6", 1'b1, a, 'h30 + a);
        for (int a = 0; a < 4; a++) step("R6", 1'b0, a, 0);
        step("R8", 1'b0, 5, 0);

        // R7: latches persist; back-to-back low writes
        step("R7", 1'b1, 7, 'h11);
        step("R7", 1'b1, 7, 'h22);
        step("R7", 1'b1, 7, 'h33);
        step("R7", 1'b1, 5, 'h44);
        step("R7", 1'b1, 7, 'h55);
        step("R7", 1'b0, 0, 0);

        // R5: 32-bit host write, top byte dropped
        step("R5", 1'b1, 4, 'h99);
        step("R5", 1'b1, 5, 'h12);
        step("R5", 1'b1, 6, 'h34);
        step("R5", 1'b1, 7, 'h56);
        step("R5", 1'b0, 4, 0);

        // R9: enable low leaves everything alone
        step("R9", 1'b0, 7, 'hFF);
        step("R9", 1'b0, 5, 'hFF);
        step("R9", 1'b0, 6, 'hFF);
        step("R9", 1'b0, 7, 0);

        // R2/R3: upper writes after a transfer do not disturb the register
        step("R2", 1'b1, 5, 'h01);
        step("R3", 1'b1, 6, 'h02);
        step("R4", 1'b1, 7, 'h03);
        step("R4", 1'b0, 7, 0);

        // R1: reset again clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        foreach (m_lane[i]) m_lane[i] = 0;
        m_word = 0;
        m_valid = 0;
        check("R1", "rx_word", int'(rx_word), 0);
        for (int a = 5; a <= 7; a++) step("R1", 1'b0, a, 0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule